// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block copies a run of bytes from a source region of memory to a destination region over one shared 8-bit memory bus. Two channels hold the addresses and counts. The source channel (channel 0) supplies the read address. The destination channel (channel 1) supplies the write address, and its count sets the length of the block.

Each byte takes eight clock states. The first four states read the source byte and hold it in an internal temporary register. The last four states drive that byte to the destination address. Software programs the registers through a simple write port and then sets the channel 0 request bit to start the copy.

The copy ends in one of two ways:
- The destination count steps down from zero to all-ones.
- An external end-of-process input is asserted. The copy then stops once the current byte has been written.

A command bit can freeze the source address. One source byte then fills the whole destination region.

Top module: `m2m_dma`

## Requirements
- R1: After reset the read strobe, write strobe and end-of-process output are high, the data bus driver is off, the command register is cleared and both channel mask bits are set. A request made before software clears the mask starts no transfer.
- R2: Each byte takes eight states, S11 to S14 and then S21 to S24. The read strobe (active low) is low in S12 and S13, and the byte is latched at the end of S13. The write strobe (active low) is low in S22 and S23. A block of N bytes gives exactly 2N read-strobe cycles and 2N write-strobe cycles.
- R3: During the read phase, mem_addr carries the channel 0 current address. During the write phase, mem_addr carries the channel 1 current address, data_oe is high for S21 to S24, and data_out carries the latched source byte. The read and write strobes are never low together.
- R4: After each byte, both current addresses step by one and the channel 1 count drops by one. Mode bit 1 of each channel picks the direction: 0 counts up and 1 counts down.
- R5: While command bit 1 is set, the channel 0 address never changes. Every destination byte then receives the byte at the source base address.
- R6: The block length is channel 1 count + 1 bytes. eop_out_n goes low for exactly one state: S24 of the byte in which the channel 1 count is zero. That is cycle 8N+1, counting the cycle after the request write as cycle 1.
- R7: A low level on eop_in_n in any state of byte k ends the block after byte k's write phase. Exactly k+1 bytes are moved, and eop_out_n stays high unless the count also ran out.
- R8: A transfer starts only when command bit 0 is set, request bit 0 is set and the channel 0 mask is clear. With command bit 0 clear, a request causes no bus activity.
- R9: Mode bits 6 to 3 (the transfer-type and transfer-mode fields) have no effect. The transfer always runs as one block.
- R10: The channel 0 count has no effect on the length of the block.
- R11: If channel 1's autoinitialize bit (mode bit 2) is clear, then at the end of the block the request bit clears and both mask bits set. A new request then starts no transfer.
- R12: If channel 1's autoinitialize bit is set, then at the end of the block each channel with its own autoinitialize bit set reloads its base address and count, the masks stay clear and the request bit clears. A new request repeats the same block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 command, 1 mode, 2 request, 3 mask, 4 ch0 address, 5 ch0 count, 6 ch1 address, 7 ch1 count |
| reg_wdata | input | 16 | Write data; control registers use the low byte. Mode bit 0 selects the channel; request bit 0 is the ch0 request; mask bits 1:0 mask ch1:ch0 |
| mem_addr | output | 16 | Memory address; zero while idle |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| data_in | input | 8 | Read data from memory |
| data_out | output | 8 | Write data to memory |
| data_oe | output | 1 | Data bus drive enable |
| eop_in_n | input | 1 | External end-of-process, active low |
| eop_out_n | output | 1 | Terminal-count end-of-process, active low |

## Verification
A request written on clock edge E0 moves the engine into S11 on the next edge, E1. The bench counts cycles from the negative edge that follows E0, calling that cycle 1. In that numbering, the read strobe of byte i is due in cycles 8i+3 and 8i+4, the write strobe in cycles 8i+7 and 8i+8, and the end-of-process pulse in cycle 8N+1 only.

An external end-of-process is pulled low for one cycle c and is sampled at the next edge, so the bench expects (c-2)/8+1 bytes. Strobes, address and data are sampled on negative edges. Memory contents are compared only after a settling window that follows the last expected write.

// File: rtl/m2m_dma_pkg.sv
package m2m_dma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_R1   = 4'd1,
    ST_R2   = 4'd2,
    ST_R3   = 4'd3,
    ST_R4   = 4'd4,
    ST_W1   = 4'd5,
    ST_W2   = 4'd6,
    ST_W3   = 4'd7,
    ST_W4   = 4'd8
  } m2m_state_e;

  localparam logic [2:0] SEL_CMD  = 3'd0;
  localparam logic [2:0] SEL_MODE = 3'd1;
  localparam logic [2:0] SEL_REQ  = 3'd2;
  localparam logic [2:0] SEL_MASK = 3'd3;
  localparam logic [2:0] SEL_ADR0 = 3'd4;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              step_i,
  input  logic              hold_i,
  input  logic              dec_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cnt_zero_o
);

  logic [ADDR_W-1:0] base_addr_q, base_addr_d;
  logic [ADDR_W-1:0] cur_addr_q,  cur_addr_d;
  logic [CNT_W-1:0]  base_cnt_q,  base_cnt_d;
  logic [CNT_W-1:0]  cur_cnt_q,   cur_cnt_d;
  logic              addr_en, cnt_en;

  always_comb begin
    base_addr_d = base_addr_q;
    cur_addr_d  = cur_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_cnt_d   = cur_cnt_q;
    addr_en     = 1'b0;
    cnt_en      = 1'b0;
    if (ld_addr_i) begin
      base_addr_d = addr_wdata_i;
      cur_addr_d  = addr_wdata_i;
      addr_en     = 1'b1;
    end else if (reload_i) begin
      cur_addr_d  = base_addr_q;
      addr_en     = 1'b1;
    end else if (step_i && !hold_i) begin
      cur_addr_d  = dec_i ? (cur_addr_q - 1'b1) : (cur_addr_q + 1'b1);
      addr_en     = 1'b1;
    end
    if (ld_cnt_i) begin
      base_cnt_d = cnt_wdata_i;
      cur_cnt_d  = cnt_wdata_i;
      cnt_en     = 1'b1;
    end else if (reload_i) begin
      cur_cnt_d  = base_cnt_q;
      cnt_en     = 1'b1;
    end else if (step_i) begin
      cur_cnt_d  = cur_cnt_q - 1'b1;
      cnt_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (addr_en) begin
      base_addr_q <= base_addr_d;
      cur_addr_q  <= cur_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else if (cnt_en) begin
      base_cnt_q <= base_cnt_d;
      cur_cnt_q  <= cur_cnt_d;
    end
  end

  assign addr_o     = cur_addr_q;
  assign cnt_zero_o = (cur_cnt_q == '0);

endmodule

// File: rtl/m2m_dma_regs.sv
module m2m_dma_regs
  import m2m_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        wdata_i,
  input  logic              term_i,
  output logic              cmd_en_o,
  output logic              cmd_hold_o,
  output logic [NUM_CH-1:0] dec_o,
  output logic [NUM_CH-1:0] auto_o,
  output logic              req0_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] ld_addr_o,
  output logic [NUM_CH-1:0] ld_cnt_o
);

  logic [1:0]        cmd_q, cmd_d;
  logic              req_q, req_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] dec_q, auto_q;
  logic              cmd_wr, req_wr, mask_wr, mode_wr;

  assign cmd_wr  = we_i && (sel_i == SEL_CMD);
  assign req_wr  = we_i && (sel_i == SEL_REQ);
  assign mask_wr = we_i && (sel_i == SEL_MASK);
  assign mode_wr = we_i && (sel_i == SEL_MODE);

  always_comb begin
    cmd_d  = cmd_wr  ? wdata_i[1:0] : cmd_q;
    req_d  = req_wr  ? wdata_i[0]   : req_q;
    mask_d = mask_wr ? wdata_i[NUM_CH-1:0] : mask_q;
    if (term_i) begin
      req_d = 1'b0;
      if (!auto_q[1]) mask_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      req_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      cmd_q  <= cmd_d;
      req_q  <= req_d;
      mask_q <= mask_d;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mode
    logic sel_this;
    assign sel_this = mode_wr && (wdata_i[0] == ch[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dec_q[ch]  <= 1'b0;
        auto_q[ch] <= 1'b0;
      end else if (sel_this) begin
        dec_q[ch]  <= wdata_i[1];
        auto_q[ch] <= wdata_i[2];
      end
    end
    assign ld_addr_o[ch] = we_i && (sel_i == (SEL_ADR0 + 3'(2*ch)));
    assign ld_cnt_o[ch]  = we_i && (sel_i == (SEL_ADR0 + 3'(2*ch + 1)));
  end

  assign cmd_en_o   = cmd_q[0];
  assign cmd_hold_o = cmd_q[1];
  assign dec_o      = dec_q;
  assign auto_o     = auto_q;
  assign req0_o     = req_q;
  assign mask_o     = mask_q;

endmodule

// File: rtl/m2m_dma_seq.sv
module m2m_dma_seq
  import m2m_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              eop_in_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_phase_o,
  output logic              wr_phase_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o,
  output logic              eop_out_n_o,
  output logic              step_o,
  output logic              term_o
);

  m2m_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] temp_q;
  logic              temp_en;
  logic              active;

  assign active = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    term_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_R1;
      ST_R1:   state_d = ST_R2;
      ST_R2:   state_d = ST_R3;
      ST_R3:   state_d = ST_R4;
      ST_R4:   state_d = ST_W1;
      ST_W1:   state_d = ST_W2;
      ST_W2:   state_d = ST_W3;
      ST_W3:   state_d = ST_W4;
      ST_W4: begin
        step_o = 1'b1;
        if (last_i || pend_q || !eop_in_n_i) begin
          term_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_R1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (term_o)                       pend_d = 1'b0;
    else if (active && !eop_in_n_i)   pend_d = 1'b1;
  end

  assign temp_en = (state_q == ST_R3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (temp_en) temp_q <= data_i;
  end

  assign rd_phase_o  = (state_q == ST_R1) || (state_q == ST_R2) ||
                       (state_q == ST_R3) || (state_q == ST_R4);
  assign wr_phase_o  = (state_q == ST_W1) || (state_q == ST_W2) ||
                       (state_q == ST_W3) || (state_q == ST_W4);
  assign rd_n_o      = !((state_q == ST_R2) || (state_q == ST_R3));
  assign wr_n_o      = !((state_q == ST_W2) || (state_q == ST_W3));
  assign oe_o        = wr_phase_o;
  assign data_o      = temp_q;
  assign eop_out_n_o = !((state_q == ST_W4) && last_i);

endmodule

// File: rtl/m2m_dma.sv
module m2m_dma
  import m2m_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              eop_in_n,
  output logic              eop_out_n
);

  logic              cmd_en, cmd_hold, req0;
  logic [NUM_CH-1:0] dec, autoi, mask, ld_addr, ld_cnt, cnt_zero, hold_v;
  logic [ADDR_W-1:0] ch_addr [NUM_CH];
  logic              step, term, rd_phase, wr_phase, start;

  m2m_dma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we),
    .sel_i      (reg_sel),
    .wdata_i    (reg_wdata[7:0]),
    .term_i     (term),
    .cmd_en_o   (cmd_en),
    .cmd_hold_o (cmd_hold),
    .dec_o      (dec),
    .auto_o     (autoi),
    .req0_o     (req0),
    .mask_o     (mask),
    .ld_addr_o  (ld_addr),
    .ld_cnt_o   (ld_cnt)
  );

  assign hold_v = {1'b0, cmd_hold};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    m2m_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_addr_i    (ld_addr[ch]),
      .ld_cnt_i     (ld_cnt[ch]),
      .addr_wdata_i (reg_wdata[ADDR_W-1:0]),
      .cnt_wdata_i  (reg_wdata[CNT_W-1:0]),
      .step_i       (step),
      .hold_i       (hold_v[ch]),
      .dec_i        (dec[ch]),
      .reload_i     (term && autoi[1] && autoi[ch]),
      .addr_o       (ch_addr[ch]),
      .cnt_zero_o   (cnt_zero[ch])
    );
  end

  assign start = cmd_en && req0 && !mask[0];

  m2m_dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .last_i      (cnt_zero[1]),
    .eop_in_n_i  (eop_in_n),
    .data_i      (data_in),
    .rd_phase_o  (rd_phase),
    .wr_phase_o  (wr_phase),
    .rd_n_o      (mem_rd_n),
    .wr_n_o      (mem_wr_n),
    .data_o      (data_out),
    .oe_o        (data_oe),
    .eop_out_n_o (eop_out_n),
    .step_o      (step),
    .term_o      (term)
  );

  always_comb begin
    if (rd_phase)      mem_addr = ch_addr[0];
    else if (wr_phase) mem_addr = ch_addr[1];
    else               mem_addr = '0;
  end

endmodule

// File: rtl/m2m_dma_chk.sv
module m2m_dma_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              eop_out_n
);

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  a_r3_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> data_oe);

  a_r2_read_two_states: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |=> !mem_rd_n);

  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> ##2 $fell(mem_wr_n));

  a_r3_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(data_out) && $stable(mem_addr)));

  a_r6_eop_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_out_n |=> eop_out_n);

  a_r6_eop_in_last_state: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_out_n |-> (mem_wr_n && data_oe && $past(!mem_wr_n)));

endmodule

bind m2m_dma m2m_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_m2m_dma_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .data_out  (data_out),
  .data_oe   (data_oe),
  .eop_out_n (eop_out_n)
);

// File: tb/m2m_dma_bench.sv
module m2m_dma_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] mem_addr;
  logic        mem_rd_n, mem_wr_n, data_oe, eop_out_n;
  logic [7:0]  data_in, data_out;
  logic        eop_in_n = 1'b1;

  logic [7:0]  mem [0:65535];

  int vec_cnt = 0;
  int fail_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit mon_en = 1'b0;
  logic [15:0] m_src, m_dst;
  bit m_dec0, m_dec1, m_hold;

  always #10 clk = ~clk;

  m2m_dma u_m2m_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .data_in   (data_in),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .eop_in_n  (eop_in_n),
    .eop_out_n (eop_out_n)
  );

  assign data_in = mem[mem_addr];

  always @(posedge clk) begin
    if (!mem_wr_n) mem[mem_addr] <= data_out;
  end

  function automatic logic [15:0] exp_addr(input logic [15:0] base, input int i, input bit dec);
    return dec ? (base - 16'(i)) : (base + 16'(i));
  endfunction

  function automatic logic [15:0] exp_src(input int i);
    return m_hold ? m_src : exp_addr(m_src, i, m_dec0);
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    vec_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // R3 / R4 / R5: address and data on every strobe cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (!mem_rd_n) begin
        chk(mem_addr == exp_src(rd_cnt / 2), "R3 read address", mem_addr, exp_src(rd_cnt / 2));
        rd_cnt++;
      end
      if (!mem_wr_n) begin
        chk(mem_addr == exp_addr(m_dst, wr_cnt / 2, m_dec1), "R4 write address",
            mem_addr, exp_addr(m_dst, wr_cnt / 2, m_dec1));
        chk(data_out == mem[exp_src(wr_cnt / 2)] && data_oe, "R3 write data",
            data_out, mem[exp_src(wr_cnt / 2)]);
        wr_cnt++;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle_window(input int n, input string rq);
    int act = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!mem_rd_n || !mem_wr_n || data_oe) act++;
    end
    chk(act == 0, rq, act, 0);
  endtask

  task automatic run_xfer(input logic [15:0] src, input logic [15:0] dst,
                          input logic [15:0] c1, input logic [15:0] c0,
                          input bit dec0, input bit dec1, input bit hold, input bit aut,
                          input logic [3:0] junk, input int eop_at, input bit cfg,
                          input string rq);
    int nfull = int'(c1) + 1;
    int nexp = nfull;
    bit internal_end = 1'b1;
    int first = 0;
    int lows = 0;
    if (eop_at > 0) begin
      int kx = (eop_at - 2) / 8;
      if (kx + 1 < nfull) begin
        nexp = kx + 1;
        internal_end = 1'b0;
      end
    end
    if (cfg) begin
      wr_reg(3'd0, {14'd0, hold, 1'b1});
      wr_reg(3'd1, {9'd0, junk, aut, dec0, 1'b0});
      wr_reg(3'd1, {9'd0, ~junk, aut, dec1, 1'b1});
      wr_reg(3'd4, src);
      wr_reg(3'd5, c0);
      wr_reg(3'd6, dst);
      wr_reg(3'd7, c1);
      wr_reg(3'd3, 16'd0);
    end
    m_src = src; m_dst = dst; m_dec0 = dec0; m_dec1 = dec1; m_hold = hold;
    rd_cnt = 0; wr_cnt = 0; mon_en = 1'b1;
    wr_reg(3'd2, 16'd1);
    for (int c = 1; c <= 8 * nexp + 12; c++) begin
      if (c > 1) @(negedge clk);
      eop_in_n = (c == eop_at) ? 1'b0 : 1'b1;
      if (!eop_out_n) begin
        lows++;
        if (first == 0) first = c;
      end
    end
    eop_in_n = 1'b1;
    mon_en = 1'b0;
    if (internal_end) begin
      chk(first == 8 * nexp + 1, {rq, " R6 eop cycle"}, first, 8 * nexp + 1);
      chk(lows == 1, {rq, " R6 eop width"}, lows, 1);
    end else begin
      chk(lows == 0, {rq, " R7 no eop pulse"}, lows, 0);
    end
    chk(rd_cnt == 2 * nexp, {rq, " R2 read strobes"}, rd_cnt, 2 * nexp);
    chk(wr_cnt == 2 * nexp, {rq, " R2 write strobes"}, wr_cnt, 2 * nexp);
    for (int i = 0; i < nexp; i++) begin
      logic [15:0] da = exp_addr(dst, i, dec1);
      logic [15:0] sa = exp_src(i);
      chk(mem[da] == mem[sa], {rq, " R4 copied byte"}, mem[da], mem[sa]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_rd_n === 1'b1, "R1 read strobe", mem_rd_n, 1);
    chk(mem_wr_n === 1'b1, "R1 write strobe", mem_wr_n, 1);
    chk(eop_out_n === 1'b1, "R1 eop out", eop_out_n, 1);
    chk(data_oe === 1'b0, "R1 drive off", data_oe, 0);
    // R1 masks set after reset
    wr_reg(3'd0, 16'd1);
    wr_reg(3'd7, 16'd3);
    wr_reg(3'd2, 16'd1);
    idle_window(24, "R1 masked after reset");
    wr_reg(3'd2, 16'd0);
    // R8 command enable clear
    wr_reg(3'd0, 16'd0);
    wr_reg(3'd3, 16'd0);
    wr_reg(3'd2, 16'd1);
    idle_window(24, "R8 disabled engine");
    wr_reg(3'd2, 16'd0);

    run_xfer(16'h1200, 16'h8200, 16'd0, 16'd7, 0, 0, 0, 0, 4'h0, 0, 1, "R6 single byte");
    run_xfer(16'h1300, 16'h8300, 16'd2, 16'd5, 0, 0, 0, 0, 4'h0, 0, 1, "R10 ch0 count ignored");
    run_xfer(16'h1400, 16'h8400, 16'd5, 16'd5, 0, 0, 1, 0, 4'h0, 0, 1, "R5 hold source");
    run_xfer(16'h1500, 16'h8500, 16'd4, 16'd4, 1, 1, 0, 0, 4'hF, 0, 1, "R4 R9 decrement");
    // R11 masks set after plain termination
    wr_reg(3'd2, 16'd1);
    idle_window(24, "R11 masked after end");
    wr_reg(3'd2, 16'd0);
    // R12 autoinitialize
    run_xfer(16'h1600, 16'h8600, 16'd2, 16'd2, 0, 1, 0, 1, 4'h5, 0, 1, "R12 first pass");
    run_xfer(16'h1600, 16'h8600, 16'd2, 16'd2, 0, 1, 0, 1, 4'h5, 0, 0, "R12 repeat pass");
    // R7 external end during byte 2
    run_xfer(16'h1700, 16'h8700, 16'd9, 16'd9, 0, 0, 0, 0, 4'h0, 19, 1, "R7 external end");

    for (int t = 0; t < 12; t++) begin
      logic [15:0] c1 = 16'($urandom % 20);
      int ea = 0;
      if (($urandom % 3) == 0) ea = 2 + 8 * int'($urandom % (int'(c1) + 1)) + int'($urandom % 8);
      run_xfer(16'h1100 + 16'($urandom % 16'h0c00), 16'h8100 + 16'($urandom % 16'h0c00),
               c1, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0,
               4'($urandom), ea, 1, "R9 random block");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

endmodule